// File: doc/BRIEF.md
# SD Card Single-Block Read Receiver

This block takes over the SPI side of an SD card once a read command has been accepted. It asks a byte exchange engine for one byte at a time and always sends 0xFF. It waits for the card's start-of-data token and then passes the requested number of payload bytes downstream, one strobe per byte. After the payload it reads the two CRC bytes and discards them. When it finishes, it raises a single completion pulse with a pass/fail flag and a two-bit cause.

The controller starts a read by pulsing `start` with the expected payload length on `byte_count`. The length is checked before any SPI traffic takes place. Exchanges go through a level request and a one-cycle acknowledge: `xch_req` stays high for as long as the receiver still wants bytes, and each `xch_ack` delivers one received byte on `xch_rx`. Waiting for the token is limited by a try budget that belongs to this block alone (`TOKEN_TRIES`). This budget is separate from, and shorter than, any ready-wait the command layer may use. CRC bytes are consumed but not verified.

Top module: `sd_block_rx`

## Requirements
- R1: After reset the block is idle. `busy`, `xch_req`, `pl_valid` and `done` are 0, and `err_code` is 0.
- R2: A `start` whose `byte_count` is zero, is not a multiple of 4, or exceeds `MAX_BYTES` completes without any exchange. `done` rises in the cycle after `start` is sampled, with `ok`=0 and `err_code`=2'd1.
- R3: While it waits for the token, the block keeps `xch_req` high with `xch_tx`=0xFF, and every received 0xFF keeps it waiting.
- R4: The first received byte that is not 0xFF and equals 0xFE starts the payload phase.
- R5: A first non-0xFF byte other than 0xFE ends the read with `ok`=0 and `err_code`=2'd3. No payload strobe is produced and no further exchange is made.
- R6: If `TOKEN_TRIES` consecutive 0xFF bytes arrive while waiting, the read ends with `ok`=0 and `err_code`=2'd2, after exactly `TOKEN_TRIES` exchanges. If the token arrives after `TOKEN_TRIES`-1 filler bytes, the read still succeeds.
- R7: Each payload byte appears on `pl_data` with `pl_valid` high for one cycle. That cycle is the one after its acknowledge. Bytes appear in arrival order, and exactly `byte_count` of them are produced.
- R8: After the payload, exactly two more bytes are exchanged. Neither is presented on the payload interface.
- R9: `done` is a one-cycle pulse. On success it comes in the cycle after the second CRC byte's acknowledge, with `ok`=1 and `err_code`=2'd0. `xch_req` is low from that cycle on, and `ok`/`err_code` hold until the next accepted start.
- R10: A `start` pulse while `busy` is high is ignored and does not disturb the read in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block read (taken only while idle) |
| byte_count | input | $clog2(MAX_BYTES+1) | Payload length in bytes, sampled with start |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Last read succeeded |
| err_code | output | 2 | 0 none, 1 bad length, 2 token timeout, 3 bad token |
| xch_req | output | 1 | Request for SPI byte exchanges |
| xch_tx | output | 8 | Byte to send, always 0xFF |
| xch_ack | input | 1 | One exchange finished; xch_rx valid |
| xch_rx | input | 8 | Byte received from the card |
| pl_valid | output | 1 | Payload byte strobe |
| pl_data | output | 8 | Payload byte |

## Verification
The assertions assume that the exchange engine acknowledges only while `xch_req` is high, and that each acknowledge lasts one cycle and delivers one byte. The bench's responder model follows this. After each acknowledge it lowers `xch_ack` for at least one cycle (more when a gap is configured), and it never acknowledges once the request has dropped. The counting checks (filler bytes before a timeout, payload strobes before a successful finish) rely on the fact that a new read can start only after the previous one has completed.

// File: rtl/sdbr_pkg.sv
package sdbr_pkg;

  localparam logic [7:0] FILLER_BYTE = 8'hFF;
  localparam logic [7:0] DATA_TOKEN  = 8'hFE;
  localparam int         CRC_BYTES   = 2;

  typedef enum logic [1:0] {
    RES_NONE    = 2'd0,
    RES_BAD_LEN = 2'd1,
    RES_TIMEOUT = 2'd2,
    RES_BAD_TOK = 2'd3
  } result_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HUNT = 2'd1,
    PH_DATA = 2'd2,
    PH_CRC  = 2'd3
  } phase_e;

  // Accept a length only when it is nonzero, word aligned and fits the buffer budget.
  function automatic logic count_ok(input logic [31:0] n, input int unsigned max_bytes);
    return (n != 32'd0) && (n[1:0] == 2'b00) && (n <= 32'(max_bytes));
  endfunction

  // Byte class seen while waiting for the token.
  function automatic logic is_filler(input logic [7:0] b);
    return b == FILLER_BYTE;
  endfunction

  function automatic logic is_token(input logic [7:0] b);
    return b == DATA_TOKEN;
  endfunction

endpackage

// File: rtl/sdbr_token_timer.sv
module sdbr_token_timer #(
  parameter int TRIES = 100,
  localparam int TW = (TRIES < 2) ? 1 : $clog2(TRIES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic last_try
);

  localparam logic [TW-1:0] LAST = TW'(TRIES - 1);

  logic [TW-1:0] tries_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tries_q <= '0;
    end else if (clear) begin
      tries_q <= '0;
    end else if (tick && !last_try) begin
      tries_q <= tries_q + TW'(1);
    end
  end

  assign last_try = (tries_q == LAST);

endmodule

// File: rtl/sdbr_byte_ctr.sv
module sdbr_byte_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);

  logic [W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= load_val;
    end else if (dec && (left_q != '0)) begin
      left_q <= left_q - W'(1);
    end
  end

  assign last = (left_q == W'(1));

endmodule

// File: rtl/sdbr_classify.sv
module sdbr_classify (
  input  logic [7:0] rx_byte,
  output logic       filler,
  output logic       token,
  output logic       stray
);

  import sdbr_pkg::*;

  always_comb begin
    filler = is_filler(rx_byte);
    token  = is_token(rx_byte);
    stray  = !filler && !token;
  end

endmodule

// File: rtl/sd_block_rx.sv
module sd_block_rx #(
  parameter int MAX_BYTES   = 512,
  parameter int TOKEN_TRIES = 100,
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] byte_count,
  output logic          busy,
  output logic          done,
  output logic          ok,
  output logic [1:0]    err_code,
  output logic          xch_req,
  output logic [7:0]    xch_tx,
  input  logic          xch_ack,
  input  logic [7:0]    xch_rx,
  output logic          pl_valid,
  output logic [7:0]    pl_data
);

  import sdbr_pkg::*;

  phase_e        phase_q, phase_d;
  logic [CW-1:0] count_q;
  logic          done_q, ok_q, valid_q;
  logic [1:0]    err_q;
  logic [7:0]    data_q;

  // Named internal events, also observed by the checker.
  logic accept_evt, len_good, byte_in, in_hunt;
  logic cls_filler, cls_token, cls_stray;
  logic hunt_fill_evt, hunt_tok_evt, hunt_bad_evt, tmo_evt;
  logic data_byte_evt, data_end_evt, crc_byte_evt, crc_end_evt;
  logic bad_len_evt, finish_evt;
  logic last_try, ctr_last, ctr_load;
  logic [CW-1:0] ctr_load_val;
  result_e result_d;

  assign accept_evt = start && (phase_q == PH_IDLE);
  assign len_good   = count_ok(32'(byte_count), MAX_BYTES);
  assign byte_in    = xch_ack && (phase_q != PH_IDLE);
  assign in_hunt    = (phase_q == PH_HUNT);

  sdbr_classify u_cls (
    .rx_byte (xch_rx),
    .filler  (cls_filler),
    .token   (cls_token),
    .stray   (cls_stray)
  );

  assign hunt_fill_evt = in_hunt && byte_in && cls_filler;
  assign hunt_tok_evt  = in_hunt && byte_in && cls_token;
  assign hunt_bad_evt  = in_hunt && byte_in && cls_stray;
  assign tmo_evt       = hunt_fill_evt && last_try;

  assign data_byte_evt = (phase_q == PH_DATA) && byte_in;
  assign data_end_evt  = data_byte_evt && ctr_last;
  assign crc_byte_evt  = (phase_q == PH_CRC) && byte_in;
  assign crc_end_evt   = crc_byte_evt && ctr_last;

  assign bad_len_evt = accept_evt && !len_good;
  assign finish_evt  = bad_len_evt || hunt_bad_evt || tmo_evt || crc_end_evt;

  sdbr_token_timer #(.TRIES(TOKEN_TRIES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept_evt),
    .tick     (hunt_fill_evt),
    .last_try (last_try)
  );

  assign ctr_load     = hunt_tok_evt || data_end_evt;
  assign ctr_load_val = hunt_tok_evt ? count_q : CW'(CRC_BYTES);

  sdbr_byte_ctr #(.W(CW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctr_load),
    .load_val (ctr_load_val),
    .dec      (data_byte_evt || crc_byte_evt),
    .last     (ctr_last)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (accept_evt && len_good) phase_d = PH_HUNT;
      PH_HUNT: begin
        if (hunt_tok_evt)                      phase_d = PH_DATA;
        else if (hunt_bad_evt || tmo_evt)      phase_d = PH_IDLE;
      end
      PH_DATA: if (data_end_evt) phase_d = PH_CRC;
      PH_CRC:  if (crc_end_evt)  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    result_d = RES_NONE;
    if (bad_len_evt)       result_d = RES_BAD_LEN;
    else if (hunt_bad_evt) result_d = RES_BAD_TOK;
    else if (tmo_evt)      result_d = RES_TIMEOUT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      count_q <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 2'd0;
      valid_q <= 1'b0;
      data_q  <= 8'h00;
    end else begin
      phase_q <= phase_d;
      done_q  <= finish_evt;
      valid_q <= data_byte_evt;
      if (accept_evt) count_q <= byte_count;
      if (data_byte_evt) data_q <= xch_rx;
      if (finish_evt) begin
        ok_q  <= crc_end_evt;
        err_q <= result_d;
      end else if (accept_evt) begin
        ok_q  <= 1'b0;
        err_q <= 2'd0;
      end
    end
  end

  assign busy     = (phase_q != PH_IDLE);
  assign xch_req  = busy;
  assign xch_tx   = FILLER_BYTE;
  assign done     = done_q;
  assign ok       = ok_q;
  assign err_code = err_q;
  assign pl_valid = valid_q;
  assign pl_data  = data_q;

endmodule

// File: rtl/sd_block_rx_chk.sv
module sd_block_rx_chk #(
  parameter int MAX_BYTES   = 512,
  parameter int TOKEN_TRIES = 100,
  parameter int CW          = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CW-1:0] byte_count,
  input logic          busy,
  input logic          done,
  input logic          ok,
  input logic [1:0]    err_code,
  input logic          xch_req,
  input logic          xch_ack,
  input logic [7:0]    xch_rx,
  input logic          pl_valid,
  input logic          in_hunt,
  input logic          hunt_bad_evt,
  input logic          accept_evt
);

  import sdbr_pkg::*;

  logic [31:0]   fill_cnt, pl_cnt;
  logic [CW-1:0] want_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      pl_cnt   <= '0;
      want_q   <= '0;
    end else if (accept_evt) begin
      fill_cnt <= '0;
      pl_cnt   <= '0;
      want_q   <= byte_count;
    end else begin
      if (in_hunt && xch_ack && (xch_rx == FILLER_BYTE)) fill_cnt <= fill_cnt + 32'd1;
      if (pl_valid) pl_cnt <= pl_cnt + 32'd1;
    end
  end

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    xch_ack |-> xch_req); // R3

  AST_BAD_LEN_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !count_ok(32'(byte_count), MAX_BYTES)) |=> (done && !ok && err_code == 2'd1 && !xch_req)); // R2

  AST_BAD_TOKEN_END: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_bad_evt |=> (done && !ok && err_code == 2'd3 && !xch_req)); // R5

  AST_TIMEOUT_TRIES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'd2) |-> (fill_cnt == 32'(TOKEN_TRIES))); // R6

  AST_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid |-> $past(xch_ack)); // R7

  AST_PAYLOAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |-> (pl_cnt == 32'(want_q))); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_REQ_DROPS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !xch_req); // R9

endmodule

bind sd_block_rx sd_block_rx_chk #(
  .MAX_BYTES   (MAX_BYTES),
  .TOKEN_TRIES (TOKEN_TRIES),
  .CW          (CW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .byte_count   (byte_count),
  .busy         (busy),
  .done         (done),
  .ok           (ok),
  .err_code     (err_code),
  .xch_req      (xch_req),
  .xch_ack      (xch_ack),
  .xch_rx       (xch_rx),
  .pl_valid     (pl_valid),
  .in_hunt      (in_hunt),
  .hunt_bad_evt (hunt_bad_evt),
  .accept_evt   (accept_evt)
);

// File: tb/sd_block_rx_tb.sv
`timescale 1ns/1ps
module sd_block_rx_tb;

  localparam int MAXB  = 512;
  localparam int TRIES = 24;
  localparam int CW    = $clog2(MAXB + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] byte_count = '0;
  logic          busy, done, ok, xch_req, pl_valid;
  logic [1:0]    err_code;
  logic [7:0]    xch_tx, pl_data;
  logic          xch_ack = 1'b0;
  logic [7:0]    xch_rx = 8'h00;

  always #2 clk = ~clk;

  sd_block_rx #(.MAX_BYTES(MAXB), .TOKEN_TRIES(TRIES)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .busy(busy), .done(done), .ok(ok), .err_code(err_code),
    .xch_req(xch_req), .xch_tx(xch_tx), .xch_ack(xch_ack), .xch_rx(xch_rx),
    .pl_valid(pl_valid), .pl_data(pl_data)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0] strm [0:1023];
  logic [7:0] got  [0:1023];
  int ptr = 0, xch_total = 0, got_n = 0, gap_cfg = 0;
  int bad_tx = 0, order_err = 0;
  logic ack_prev = 1'b0;

  task automatic chk(input logic cond, input string req, input int act, input int exp);
    n_run++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // Exchange engine model: one-cycle acks, optional gap, only while requested.
  initial begin
    int wait_n = 0;
    forever begin
      @(posedge clk); #1;
      if (xch_ack) begin
        xch_ack = 1'b0;
        wait_n  = gap_cfg;
      end else if (xch_req) begin
        if (xch_tx != 8'hFF) bad_tx++;
        if (wait_n > 0) wait_n--;
        else begin
          xch_ack = 1'b1;
          xch_rx  = strm[ptr];
          ptr++;
          xch_total++;
        end
      end
    end
  end

  // Payload monitor.
  always @(negedge clk) begin
    if (pl_valid) begin
      if (!ack_prev) order_err++;
      got[got_n] = pl_data;
      got_n++;
    end
    ack_prev = xch_ack;
  end

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    report();
  end

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 7 + seed * 13 + 3) & 8'hFF);
  endfunction

  task automatic load_stream(input int fillers, input logic [7:0] tok, input int n, input int seed);
    for (int i = 0; i < 1024; i++) strm[i] = 8'hFF;
    strm[fillers] = tok;
    for (int i = 0; i < n; i++) strm[fillers + 1 + i] = pat(i, seed);
    strm[fillers + 1 + n]     = 8'hC3;
    strm[fillers + 1 + n + 1] = 8'h3C;
    ptr = 0; xch_total = 0; got_n = 0; order_err = 0;
  endtask

  task automatic pulse_start(input int n);
    @(negedge clk);
    start = 1'b1; byte_count = CW'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cycles);
    cycles = 0;
    while (!done && cycles < 20000) begin @(negedge clk); cycles++; end
  endtask

  task automatic t_reset;
    chk(!busy && !xch_req && !pl_valid && !done, "R1 idle outputs", {busy, xch_req, pl_valid, done}, 0);
    chk(err_code == 2'd0 && !ok, "R1 result cleared", err_code, 0);
  endtask

  task automatic t_bad_len(input int n);
    load_stream(0, 8'hFE, 4, 1);
    @(negedge clk);
    start = 1'b1; byte_count = CW'(n);
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R2 done next cycle", done, 1);
    chk(err_code == 2'd1 && !ok, "R2 bad length code", err_code, 1);
    repeat (3) @(negedge clk);
    chk(xch_total == 0, "R2 no exchange", xch_total, 0);
  endtask

  task automatic t_good(input int fillers, input int n, input int gap, input int seed);
    int cyc, mism;
    gap_cfg = gap;
    load_stream(fillers, 8'hFE, n, seed);
    pulse_start(n);
    wait_done(cyc);
    chk(done && ok && err_code == 2'd0, "R9 success result", err_code, 0);
    chk(got_n == n, "R7 payload count", got_n, n);
    mism = 0;
    for (int i = 0; i < n; i++) if (got[i] != pat(i, seed)) mism++;
    chk(mism == 0, "R4 R7 payload order/content", mism, 0);
    chk(order_err == 0, "R7 strobe follows ack", order_err, 0);
    chk(xch_total == fillers + 1 + n + 2, "R8 two CRC exchanges", xch_total, fillers + 3 + n);
    chk(!xch_req, "R9 request dropped", xch_req, 0);
    @(negedge clk);
    chk(!done && ok && err_code == 2'd0, "R9 pulse one cycle, result held", done, 0);
    chk(bad_tx == 0, "R3 filler sent", bad_tx, 0);
  endtask

  task automatic t_bad_token(input int fillers, input logic [7:0] tok);
    int cyc;
    gap_cfg = 1;
    load_stream(fillers, tok, 16, 4);
    pulse_start(16);
    wait_done(cyc);
    chk(!ok && err_code == 2'd3, "R5 bad token code", err_code, 3);
    chk(got_n == 0, "R5 no payload", got_n, 0);
    repeat (4) @(negedge clk);
    chk(xch_total == fillers + 1, "R5 no further exchange", xch_total, fillers + 1);
  endtask

  task automatic t_timeout;
    int cyc;
    gap_cfg = 0;
    load_stream(200, 8'hFE, 16, 5);
    pulse_start(16);
    wait_done(cyc);
    chk(!ok && err_code == 2'd2, "R6 timeout code", err_code, 2);
    repeat (4) @(negedge clk);
    chk(xch_total == TRIES, "R6 exchanges before timeout", xch_total, TRIES);
    chk(got_n == 0, "R6 no payload", got_n, 0);
  endtask

  task automatic t_start_busy;
    int cyc, mism;
    gap_cfg = 3;
    load_stream(2, 8'hFE, 16, 6);
    pulse_start(16);
    repeat (30) @(negedge clk);
    start = 1'b1; byte_count = '0;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    chk(ok && err_code == 2'd0, "R10 start ignored while busy", err_code, 0);
    mism = 0;
    for (int i = 0; i < 16; i++) if (got[i] != pat(i, 6)) mism++;
    chk(got_n == 16 && mism == 0, "R10 payload intact", got_n, 16);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_len(0);
    t_bad_len(6);
    t_bad_len(MAXB + 4);
    t_good(0, 16, 0, 1);
    t_good(3, 64, 2, 2);
    t_good(5, 512, 0, 3);
    t_good(TRIES - 1, 4, 1, 7);
    t_bad_token(4, 8'h05);
    t_bad_token(0, 8'h00);
    t_timeout();
    t_start_busy();
    report();
  end

endmodule